// File: doc/BRIEF.md
# Coprocessor Dispatch Queue with Synchronised-Move Interlocks

This block sits between an in-order integer issue stage and an asynchronous packed-SIMD / floating-point coprocessor. The integer stage offers at most one instruction per cycle. Ordinary coprocessor instructions are placed in one of two per-class queues. Each queue runs its head operation for a fixed number of enabled cycles before retiring it. No arithmetic is modelled. The block returns an accept pulse and a stall signal to the integer stage, and it drives an execute-enable that lets the coprocessor queues advance.

Instructions that move data between an integer register and a SIMD register get special treatment. A move from integer to SIMD (a sync load) must wait until no queued SIMD operation names its target register. Only one such move may be in flight at a time. A move from SIMD to integer (a sync store) waits until its source register has left the SIMD queue. After acceptance, each kind holds the integer stage for a fixed number of cycles. The word-insert variant then takes a fixed number of cycles away from coprocessor execution.

Top module: `coproc_dispatch`

## Requirements
- R1: The operation class is `in_op`: 0 integer, 1 SIMD, 2 FP, 3 sync-load move, 4 sync-load word insert, 5 sync store; codes 6 and 7 are treated as integer. At most one instruction is accepted per cycle. `in_accept` and `int_stall` are never both high. After reset, with no valid input, accept and stall are low and `cop_exec_en` is high.
- R2: The SIMD queue holds 6 operations. A SIMD instruction offered while 6 are queued is not accepted and raises `int_stall`.
- R3: The FP queue holds 4 operations, with the same full rule as R2.
- R4: The head of the SIMD queue retires after 6 clock edges with `cop_exec_en` high. The head of the FP queue retires after 7 such edges. A slot becomes free only on the edge after retirement.
- R5: A sync load (codes 3 and 4) is not accepted while any queued SIMD operation names `in_dst` as its source or destination register.
- R6: A sync load is not accepted while another sync load is still occupying the integer stage or stealing coprocessor cycles. This applies whatever registers are involved.
- R7: After a sync-load move is accepted, `int_stall` is high for the next 4 cycles, so the next acceptance comes at the earliest 5 cycles later. `cop_exec_en` stays high throughout.
- R8: A word-insert sync load has the same 4-cycle stall as R7. It then drives `cop_exec_en` low for the 4 cycles that follow.
- R9: A sync store (code 5) is held until no queued SIMD operation names `in_src`. After it is accepted, `int_stall` is high for 9 cycles. The SIMD queue keeps draining during that time.
- R10: An ordinary SIMD instruction is accepted while a word insert is stealing coprocessor cycles. The only condition is that its queue has room.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Integer stage offers an instruction |
| in_op | input | 3 | Operation class code (see R1) |
| in_dst | input | 3 | SIMD destination register number |
| in_src | input | 3 | SIMD source register number |
| in_accept | output | 1 | Offered instruction is taken this cycle |
| int_stall | output | 1 | Integer stage must hold |
| cop_exec_en | output | 1 | Coprocessor queues may advance this cycle |

## Verification
A wrong queue count or head timer first shows up as an acceptance that comes one or more cycles early or late. This happens on the first SIMD or FP offer made against a full queue, within the 6 or 7 cycles of the head's lifetime. A stale register-use mask shows up as a sync load or sync store that is accepted while a conflicting operation is still queued, or that stays stalled after the queue has drained. An occupancy or steal counter that is off by one changes how many stall cycles follow an accept, or how many cycles the execute-enable stays low. That error is visible within ten cycles of the accept. A cycle-level reference model in the bench compares all three outputs on every cycle, so any divergence is reported in the cycle where it first appears.

// File: rtl/coproc_dispatch_pkg.sv
// Shared operation codes for the coprocessor dispatch block.
// Assumes a 3-bit class field; unused codes behave as integer ops.
package coproc_dispatch_pkg;
    typedef enum logic [2:0] {
        OP_INT       = 3'd0,
        OP_SIMD      = 3'd1,
        OP_FP        = 3'd2,
        OP_SL_MOVE   = 3'd3,
        OP_SL_INSERT = 3'd4,
        OP_SS        = 3'd5
    } cop_op_e;
endpackage

// File: rtl/cq_fifo.sv
// Fixed-latency operation queue: holds up to DEPTH operations, runs the
// head for LAT enabled cycles then retires it. Reports which registers
// are named by any held operation. Assumes push is never asserted when full.
module cq_fifo #(
    parameter int DEPTH = 6,
    parameter int LAT   = 6,
    parameter int NREG  = 8,
    localparam int RW   = $clog2(NREG),
    localparam int CW   = $clog2(DEPTH + 1),
    localparam int TW   = $clog2(LAT)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            push,
    input  logic [RW-1:0]   push_dst,
    input  logic [RW-1:0]   push_src,
    input  logic            exec_en,
    output logic            full,
    output logic [NREG-1:0] use_mask
);
    logic [RW-1:0] dst_q [DEPTH];
    logic [RW-1:0] src_q [DEPTH];
    logic [CW-1:0] count;
    logic [TW-1:0] timer;
    logic          pop;

    assign pop  = exec_en && (count != '0) && (timer == TW'(LAT - 1));
    assign full = (count == CW'(DEPTH));

    // Occupancy count: one in, one out per cycle at most.
    always_ff @(posedge clk) begin
        if (!rst_n) count <= '0;
        else        count <= count + CW'(push) - CW'(pop);
    end

    // Head timer: counts enabled cycles of the head operation.
    always_ff @(posedge clk) begin
        if (!rst_n)                        timer <= '0;
        else if (exec_en && count != '0)   timer <= pop ? '0 : timer + TW'(1);
    end

    // Entry storage: shift toward the head on retire, write at the tail.
    for (genvar i = 0; i < DEPTH; i++) begin : g_entry
        localparam int NXT = (i < DEPTH - 1) ? i + 1 : i;
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                dst_q[i] <= '0;
                src_q[i] <= '0;
            end else if (pop) begin
                if (push && CW'(i + 1) == count) begin
                    dst_q[i] <= push_dst;
                    src_q[i] <= push_src;
                end else begin
                    dst_q[i] <= dst_q[NXT];
                    src_q[i] <= src_q[NXT];
                end
            end else if (push && CW'(i) == count) begin
                dst_q[i] <= push_dst;
                src_q[i] <= push_src;
            end
        end
    end

    // Register-use mask over all held entries.
    always_comb begin
        use_mask = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (CW'(i) < count) begin
                use_mask[dst_q[i]] = 1'b1;
                use_mask[src_q[i]] = 1'b1;
            end
        end
    end
endmodule

// File: rtl/cq_sync_seq.sv
// Sequencer for synchronised moves: integer-stage occupancy after accept,
// then an optional window that steals coprocessor execute cycles.
// Assumes at most one start per cycle and no start while occupied.
module cq_sync_seq #(
    parameter int SL_OCC   = 5,
    parameter int SL_STEAL = 4,
    parameter int SS_OCC   = 10,
    localparam int OMAX    = (SS_OCC > SL_OCC) ? SS_OCC : SL_OCC,
    localparam int OW      = $clog2(OMAX),
    localparam int SW      = $clog2(SL_STEAL + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_load,
    input  logic start_insert,
    input  logic start_store,
    output logic occ_busy,
    output logic load_inflight,
    output logic exec_en
);
    logic [OW-1:0] occ_q;
    logic [SW-1:0] steal_q;
    logic          arm_q;

    assign occ_busy      = (occ_q != '0);
    assign exec_en       = (steal_q == '0);
    assign load_inflight = occ_busy || arm_q || !exec_en;

    // Remaining integer-stage occupancy cycles.
    always_ff @(posedge clk) begin
        if (!rst_n)           occ_q <= '0;
        else if (start_load)  occ_q <= OW'(SL_OCC - 1);
        else if (start_store) occ_q <= OW'(SS_OCC - 1);
        else if (occ_busy)    occ_q <= occ_q - OW'(1);
    end

    // Arm the steal on insert; launch it as occupancy ends.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            arm_q   <= 1'b0;
            steal_q <= '0;
        end else if (start_insert) begin
            arm_q   <= 1'b1;
        end else if (arm_q && occ_q == OW'(1)) begin
            arm_q   <= 1'b0;
            steal_q <= SW'(SL_STEAL);
        end else if (steal_q != '0) begin
            steal_q <= steal_q - SW'(1);
        end
    end
endmodule

// File: rtl/coproc_dispatch.sv
// Dispatch stage between an integer issue stage and a SIMD/FP coprocessor.
// Routes ops into per-class fixed-latency queues, stalls on full queues,
// and interlocks integer<->SIMD moves on register use and occupancy.
// Assumes the integer stage holds its offer while stalled or drops it freely.
module coproc_dispatch
    import coproc_dispatch_pkg::*;
#(
    parameter int NREG       = 8,
    parameter int SIMD_DEPTH = 6,
    parameter int FP_DEPTH   = 4,
    parameter int SIMD_LAT   = 6,
    parameter int FP_LAT     = 7,
    parameter int SL_OCC     = 5,
    parameter int SL_STEAL   = 4,
    parameter int SS_OCC     = 10,
    localparam int RW        = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [2:0]    in_op,
    input  logic [RW-1:0] in_dst,
    input  logic [RW-1:0] in_src,
    output logic          in_accept,
    output logic          int_stall,
    output logic          cop_exec_en
);
    logic            simd_full, fp_full;
    logic [NREG-1:0] simd_busy, unused_fp_mask;
    logic            occ_busy, load_inflight, can_go;
    logic            is_simd, is_fp, is_load, is_insert, is_store;

    // Class decode of the offered instruction.
    always_comb begin
        is_simd   = (in_op == OP_SIMD);
        is_fp     = (in_op == OP_FP);
        is_insert = (in_op == OP_SL_INSERT);
        is_load   = (in_op == OP_SL_MOVE) || is_insert;
        is_store  = (in_op == OP_SS);
    end

    // Readiness of the offered instruction, ignoring occupancy.
    always_comb begin
        if (is_simd)       can_go = !simd_full;
        else if (is_fp)    can_go = !fp_full;
        else if (is_load)  can_go = !load_inflight && !simd_busy[in_dst];
        else if (is_store) can_go = !simd_busy[in_src];
        else               can_go = 1'b1;
    end

    assign in_accept = in_valid && !occ_busy && can_go;
    assign int_stall = occ_busy || (in_valid && !can_go);

    cq_fifo #(.DEPTH(SIMD_DEPTH), .LAT(SIMD_LAT), .NREG(NREG)) u_simd_q (
        .clk(clk), .rst_n(rst_n),
        .push(in_accept && is_simd), .push_dst(in_dst), .push_src(in_src),
        .exec_en(cop_exec_en), .full(simd_full), .use_mask(simd_busy)
    );

    cq_fifo #(.DEPTH(FP_DEPTH), .LAT(FP_LAT), .NREG(NREG)) u_fp_q (
        .clk(clk), .rst_n(rst_n),
        .push(in_accept && is_fp), .push_dst(in_dst), .push_src(in_src),
        .exec_en(cop_exec_en), .full(fp_full), .use_mask(unused_fp_mask)
    );

    cq_sync_seq #(.SL_OCC(SL_OCC), .SL_STEAL(SL_STEAL), .SS_OCC(SS_OCC)) u_seq (
        .clk(clk), .rst_n(rst_n),
        .start_load(in_accept && is_load),
        .start_insert(in_accept && is_insert),
        .start_store(in_accept && is_store),
        .occ_busy(occ_busy), .load_inflight(load_inflight),
        .exec_en(cop_exec_en)
    );
endmodule

// File: rtl/coproc_dispatch_checker.sv
// Property checker for coproc_dispatch, attached by bind below.
// Assumes the default operation encoding from the package.
module coproc_dispatch_checker #(
    parameter int NREG = 8,
    localparam int RW  = $clog2(NREG)
) (
    input logic            clk,
    input logic            rst_n,
    input logic            in_valid,
    input logic [2:0]      in_op,
    input logic [RW-1:0]   in_dst,
    input logic            in_accept,
    input logic            int_stall,
    input logic            cop_exec_en,
    input logic            simd_full,
    input logic            fp_full,
    input logic [NREG-1:0] simd_busy
);
    assert_accept_xor_stall_R1: assert property (@(posedge clk) disable iff (!rst_n)
        in_accept |-> !int_stall);
    assert_no_overflow_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_op == 3'd1 && simd_full) |-> !in_accept);
    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_op == 3'd2 && fp_full) |-> !in_accept);
    assert_load_dependency_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_accept && (in_op == 3'd3 || in_op == 3'd4)) |-> !simd_busy[in_dst]);
    assert_load_occupancy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_accept && (in_op == 3'd3 || in_op == 3'd4 || in_op == 3'd5)) |=> int_stall);
    assert_steal_follows_stall_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cop_exec_en) |-> $past(int_stall));
endmodule

bind coproc_dispatch coproc_dispatch_checker #(.NREG(NREG)) u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
    .in_dst(in_dst), .in_accept(in_accept), .int_stall(int_stall),
    .cop_exec_en(cop_exec_en), .simd_full(simd_full), .fp_full(fp_full),
    .simd_busy(simd_busy)
);

// File: tb/coproc_dispatch_test.sv
// Bench: reference model compared every cycle, directed corners, random mix.
module coproc_dispatch_test;
    localparam int SQD = 6, FQD = 4, SLAT = 6, FLAT = 7;

    logic clk = 1'b0, rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic [2:0] in_op = '0, in_dst = '0, in_src = '0;
    logic in_accept, int_stall, cop_exec_en;

    int checks = 0, failures = 0;
    int sq_n = 0, sq_t = 0, fq_n = 0, fq_t = 0, m_occ = 0, m_steal = 0;
    bit m_arm = 0;
    int sq_d[SQD], sq_s[SQD];
    bit e_acc, e_stall, e_exec, r_acc, r_stall, r_exec;

    always #5 clk = ~clk;

    coproc_dispatch uut (.clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
        .in_dst(in_dst), .in_src(in_src), .in_accept(in_accept),
        .int_stall(int_stall), .cop_exec_en(cop_exec_en));

    function automatic string tag_of(input int op);
        case (op)
            1: return "R2";
            2: return "R3";
            3: return "R5";
            4: return "R8";
            5: return "R9";
            default: return "R1";
        endcase
    endfunction

    function automatic bit reg_used(input int r);
        for (int i = 0; i < sq_n; i++)
            if (sq_d[i] == r || sq_s[i] == r) return 1'b1;
        return 1'b0;
    endfunction

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
        end
    endtask

    // Expected outputs from the model state and the offered instruction.
    task automatic model_eval(input bit v, input int op, input int d, input int s);
        bit occ = (m_occ != 0), go;
        bit infl = occ || m_arm || (m_steal != 0);
        e_exec = (m_steal == 0);
        case (op)
            1: go = (sq_n < SQD);
            2: go = (fq_n < FQD);
            3, 4: go = !infl && !reg_used(d);
            5: go = !reg_used(s);
            default: go = 1'b1;
        endcase
        e_acc = v && !occ && go;
        e_stall = occ || (v && !go);
    endtask

    // Advance the model by one clock edge.
    task automatic model_step(input int op, input int d, input int s);
        bit pop_s = e_exec && sq_n > 0 && sq_t == SLAT - 1;
        bit pop_f = e_exec && fq_n > 0 && fq_t == FLAT - 1;
        int steal_n = (m_steal > 0) ? m_steal - 1 : 0;
        bit arm_n = m_arm;
        if (e_exec && sq_n > 0) sq_t = pop_s ? 0 : sq_t + 1;
        if (e_exec && fq_n > 0) fq_t = pop_f ? 0 : fq_t + 1;
        if (pop_s) begin
            for (int i = 0; i < SQD - 1; i++) begin sq_d[i] = sq_d[i+1]; sq_s[i] = sq_s[i+1]; end
            sq_n--;
        end
        if (pop_f) fq_n--;
        if (e_acc && op == 1) begin sq_d[sq_n] = d; sq_s[sq_n] = s; sq_n++; end
        if (e_acc && op == 2) fq_n++;
        if (m_arm && m_occ == 1) begin steal_n = 4; arm_n = 0; end
        if (e_acc && op == 4) arm_n = 1;
        if (e_acc && (op == 3 || op == 4)) m_occ = 4;
        else if (e_acc && op == 5) m_occ = 9;
        else if (m_occ > 0) m_occ--;
        m_steal = steal_n;
        m_arm = arm_n;
    endtask

    task automatic step(input bit v, input int op, input int d, input int s);
        @(negedge clk);
        in_valid = v; in_op = op[2:0]; in_dst = d[2:0]; in_src = s[2:0];
        #1;
        model_eval(v, op, d, s);
        r_acc = in_accept; r_stall = int_stall; r_exec = cop_exec_en;
        check(tag_of(op), "accept", r_acc, e_acc);
        check(e_stall ? tag_of(op) : "R1", "stall", r_stall, e_stall);
        check("R8", "exec_en", r_exec, e_exec);
        @(posedge clk);
        model_step(op, d, s);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(0, 0, 0, 0);
    endtask

    task automatic offer_until(input int op, input int d, input int s, output int tries);
        tries = 0;
        do begin step(1, op, d, s); tries++; end while (!r_acc && tries < 60);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL R1 watchdog expired actual=1 expected=0");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin : main
        int n;
        repeat (3) @(posedge clk);
        #1;
        check("R1", "reset accept", in_accept, 0);
        check("R1", "reset stall", int_stall, 0);
        check("R1", "reset exec_en", cop_exec_en, 1);
        @(negedge clk); rst_n = 1'b1;
        idle(2);

        // R2/R4: six SIMD pushes, seventh waits one cycle for head retire.
        for (int i = 0; i < 6; i++) step(1, 1, 1, 2);
        offer_until(1, 1, 2, n);
        check("R2", "SIMD offers until accept", n, 2);
        idle(50);

        // R3/R4: four FP pushes, fifth waits for 7-cycle head.
        for (int i = 0; i < 4; i++) step(1, 2, 0, 0);
        offer_until(2, 0, 0, n);
        check("R4", "FP offers until accept", n, 5);
        idle(50);

        // R5: load to a queued register waits; to a free one goes.
        step(1, 1, 5, 4);
        step(1, 3, 5, 0);
        check("R5", "load to busy reg accepted", r_acc, 0);
        step(1, 3, 6, 0);
        check("R5", "load to free reg accepted", r_acc, 1);
        idle(30);

        // R7: move holds the integer stage 4 cycles, exec stays high.
        step(1, 3, 2, 0);
        check("R7", "move accepted", r_acc, 1);
        for (int i = 0; i < 4; i++) begin
            step(0, 0, 0, 0);
            check("R7", "move occupancy stall", r_stall, 1);
            check("R7", "move exec_en", r_exec, 1);
        end
        step(0, 0, 0, 0);
        check("R7", "stall after move occupancy", r_stall, 0);
        idle(10);

        // R8/R6/R10: insert occupancy, then steal window.
        step(1, 4, 3, 0);
        check("R8", "insert accepted", r_acc, 1);
        for (int i = 0; i < 4; i++) begin
            step(0, 0, 0, 0);
            check("R8", "insert occupancy exec_en", r_exec, 1);
        end
        step(1, 3, 7, 0);
        check("R6", "second load during steal", r_acc, 0);
        check("R8", "steal exec_en low", r_exec, 0);
        step(1, 1, 1, 1);
        check("R10", "SIMD during steal", r_acc, 1);
        offer_until(3, 7, 0, n);
        check("R6", "load offers until steal ends", n, 3);
        idle(40);

        // R9: store waits for its source to drain, then 9 stall cycles.
        step(1, 1, 3, 3);
        offer_until(5, 0, 3, n);
        check("R9", "store offers until source free", n, 7);
        for (int i = 0; i < 9; i++) begin
            step(0, 0, 0, 0);
            check("R9", "store occupancy stall", r_stall, 1);
        end
        step(0, 0, 0, 0);
        check("R9", "stall after store", r_stall, 0);
        idle(10);

        // R9: queue keeps draining while a store occupies the stage.
        for (int i = 0; i < 6; i++) step(1, 1, 1, 1);
        step(1, 5, 0, 4);
        check("R9", "store with independent source", r_acc, 1);
        idle(9);
        step(1, 1, 2, 2);
        check("R9", "SIMD queue drained during store", r_acc, 1);
        idle(50);

        // Random mix with a fixed seed, compared against the model each cycle.
        void'($urandom(32'h5eed_c0de));
        for (int i = 0; i < 6000; i++) begin
            int r = $urandom_range(0, 9);
            int op = (r < 3) ? 1 : (r < 5) ? 2 : (r < 6) ? 0 : (r - 3);
            step($urandom_range(0, 3) != 0, op, $urandom_range(0, 7), $urandom_range(0, 7));
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule